// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Guard Bits

This block is the arithmetic core of a fixed-point signal processing datapath. It multiplies two 17-bit signed operands in one cycle and writes the product to one of two 40-bit accumulators, or adds it to that accumulator, or subtracts it from it. Each accumulator carries 8 guard bits above the 32-bit product range, so long sums of Q15 products stay exact well past the point where a 32-bit register would wrap.

A fractional mode shifts the raw product left by one place. This removes the duplicated sign bit that a signed-by-signed multiply produces, so a Q15 by Q15 product lands Q15-aligned in the upper half. Any multiplying operation can round its result by adding 2^15 and then zeroing the lower 16 bits. A separate operation clamps an accumulator back into the 32-bit signed range. A saturation mode applies the same clamp to every accumulate and subtract result as it is written.

Each accumulator has a sticky overflow flag. Software-facing logic outside this block issues one operation per cycle and reads both accumulators and both flags directly.

Top module: `frac_mac`

## Requirements
- R1: After reset both accumulators read zero and both overflow flags are clear.
- R2: Operation codes on `op_i` are 000 no-op, 001 zero, 010 multiply, 011 multiply-accumulate, 100 multiply-subtract, 101 saturate; 110 and 111 act as no-ops. Only the accumulator chosen by `acc_sel_i` (0 = A, 1 = B) changes, on the next rising clock edge.
- R3: With `frac_i` low, multiply writes the 34-bit signed product of `xm_i` and `ym_i`, sign-extended to 40 bits.
- R4: With `frac_i` high, the product is shifted left by one bit before use.
- R5: Multiply-accumulate writes accumulator plus product, and multiply-subtract writes accumulator minus product, in 40-bit two's complement, in one cycle.
- R6: A result outside the signed 32-bit range is kept in full in the 40-bit accumulator and sets that accumulator's overflow flag when saturation mode is off.
- R7: With `round_i` high, a multiply, accumulate or subtract result has 0x8000 added, and then bits 15..0 are cleared before it is written.
- R8: The saturate operation replaces a selected value above 0x7FFFFFFF with 0x007FFFFFFF and one below -2^31 with 0xFF80000000. In that case it also sets the overflow flag. A value already in range is left unchanged.
- R9: With `sat_mode_i` high, a multiply-accumulate or multiply-subtract result outside the 32-bit range is clamped to the same two limits as it is written. The multiply operation is not clamped.
- R10: An overflow flag stays set until its bit of `ovf_clr_i` is high at a clock edge. When a new overflow happens on the same edge as a clear, the flag stays set.
- R11: The zero operation writes 0 to the selected accumulator and leaves its overflow flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| acc_sel_i | input | 1 | Destination accumulator, 0 = A, 1 = B |
| frac_i | input | 1 | Fractional mode: shift product left by one |
| round_i | input | 1 | Round the multiply result |
| sat_mode_i | input | 1 | Clamp accumulate/subtract results to 32 bits |
| xm_i | input | 17 | Signed multiplier operand |
| ym_i | input | 17 | Signed multiplicand operand |
| ovf_clr_i | input | 2 | Per-accumulator overflow flag clear (bit 0 = A) |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ovf_o | output | 2 | Sticky overflow flags (bit 0 = A) |

## Verification
The hardest states to reach are the ones where an accumulator sits in the guard-bit region, beyond 32 bits but still inside 40. Only a chain of near-full-scale products gets there. The stimulus repeats fractional accumulates of 0x7FFF by 0x7FFF, and subtracts at full negative scale, to drive each accumulator well past both 32-bit limits. From those states it then applies the saturate operation, clears the flags, and exercises saturation mode. The extreme 17-bit operand -65536 squared, and -32768 squared in fractional mode, provide single-step overflows.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'b000,
        OP_ZERO = 3'b001,
        OP_MPY  = 3'b010,
        OP_MAC  = 3'b011,
        OP_MAS  = 3'b100,
        OP_SAT  = 3'b101,
        OP_RSV6 = 3'b110,
        OP_RSV7 = 3'b111
    } mac_op_e;

endpackage

// File: rtl/frac_mac_mult.sv
module frac_mac_mult #(
    parameter int OPND_W = 17,
    parameter int ACC_W  = 40
) (
    input  logic signed [OPND_W-1:0] x_i,
    input  logic signed [OPND_W-1:0] y_i,
    input  logic                     frac_i,
    output logic        [ACC_W-1:0]  prod_o
);
    localparam int RAW_W = 2 * OPND_W;
    localparam int EXT_W = ACC_W - RAW_W;

    logic signed [RAW_W-1:0] raw;
    logic        [ACC_W-1:0] ext;

    // Full-width signed product.
    assign raw = x_i * y_i;
    // Sign extension into the accumulator width.
    assign ext = {{EXT_W{raw[RAW_W-1]}}, raw};
    // Fractional mode drops the duplicated sign bit.
    assign prod_o = frac_i ? {ext[ACC_W-2:0], 1'b0} : ext;

endmodule

// File: rtl/frac_mac_alu.sv
module frac_mac_alu
    import frac_mac_pkg::*;
#(
    parameter int ACC_W   = 40,
    parameter int GUARD_W = 8,
    parameter int RND_BIT = 15
) (
    input  logic [2:0]       op_i,
    input  logic             sel_i,
    input  logic             round_i,
    input  logic             sat_mode_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] prod_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_set_o
);
    localparam int RANGE_W = ACC_W - GUARD_W;
    localparam int TOP_W   = GUARD_W + 1;
    localparam logic [ACC_W-1:0] POS_MAX  = {{TOP_W{1'b0}}, {(RANGE_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_MIN  = {{TOP_W{1'b1}}, {(RANGE_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] RND_ADD  = ACC_W'(1) << RND_BIT;
    localparam logic [ACC_W-1:0] RND_MASK = ~((RND_ADD << 1) - ACC_W'(1));

    logic [ACC_W-1:0] pre_sum;
    logic [ACC_W-1:0] rounded;
    logic             rnd_oor;
    logic             acc_oor;
    logic             is_mul;
    logic             can_clamp;

    function automatic logic out_of_range(input logic [ACC_W-1:0] v);
        logic [TOP_W-1:0] top;
        top = v[ACC_W-1 -: TOP_W];
        return !((&top) || !(|top));
    endfunction

    function automatic logic [ACC_W-1:0] clamp(input logic [ACC_W-1:0] v);
        return v[ACC_W-1] ? NEG_MIN : POS_MAX;
    endfunction

    always_comb begin
        is_mul    = 1'b0;
        can_clamp = 1'b0;
        pre_sum   = prod_i;
        unique case (op_i)
            OP_MPY: begin
                is_mul  = 1'b1;
                pre_sum = prod_i;
            end
            OP_MAC: begin
                is_mul    = 1'b1;
                can_clamp = 1'b1;
                pre_sum   = acc_i + prod_i;
            end
            OP_MAS: begin
                is_mul    = 1'b1;
                can_clamp = 1'b1;
                pre_sum   = acc_i - prod_i;
            end
            default: begin
                is_mul  = 1'b0;
                pre_sum = prod_i;
            end
        endcase
    end

    assign rounded = round_i ? ((pre_sum + RND_ADD) & RND_MASK) : pre_sum;
    assign rnd_oor = out_of_range(rounded);
    assign acc_oor = out_of_range(acc_i);

    always_comb begin
        acc_o     = acc_i;
        ovf_set_o = 1'b0;
        if (sel_i) begin
            if (is_mul) begin
                ovf_set_o = rnd_oor;
                acc_o     = (sat_mode_i && can_clamp && rnd_oor) ? clamp(rounded) : rounded;
            end else if (op_i == OP_ZERO) begin
                acc_o = '0;
            end else if (op_i == OP_SAT) begin
                ovf_set_o = acc_oor;
                acc_o     = acc_oor ? clamp(acc_i) : acc_i;
            end
        end
    end

endmodule

// File: rtl/frac_mac.sv
module frac_mac
    import frac_mac_pkg::*;
#(
    parameter int OPND_W  = 17,
    parameter int RANGE_W = 32,
    parameter int GUARD_W = 8,
    parameter int RND_BIT = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    op_i,
    input  logic                          acc_sel_i,
    input  logic                          frac_i,
    input  logic                          round_i,
    input  logic                          sat_mode_i,
    input  logic [OPND_W-1:0]             xm_i,
    input  logic [OPND_W-1:0]             ym_i,
    input  logic [1:0]                    ovf_clr_i,
    output logic [RANGE_W+GUARD_W-1:0]    acc_a_o,
    output logic [RANGE_W+GUARD_W-1:0]    acc_b_o,
    output logic [1:0]                    ovf_o
);
    localparam int ACC_W   = RANGE_W + GUARD_W;
    localparam int NUM_ACC = 2;

    typedef struct packed {
        logic [NUM_ACC-1:0][ACC_W-1:0] acc;
        logic [NUM_ACC-1:0]            ovf;
    } mac_state_t;

    mac_state_t state_d, state_q;

    logic [ACC_W-1:0]                prod;
    logic [NUM_ACC-1:0][ACC_W-1:0]   alu_acc;
    logic [NUM_ACC-1:0]              alu_ovf;

    frac_mac_mult #(
        .OPND_W (OPND_W),
        .ACC_W  (ACC_W)
    ) i_mult (
        .x_i    (xm_i),
        .y_i    (ym_i),
        .frac_i (frac_i),
        .prod_o (prod)
    );

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        frac_mac_alu #(
            .ACC_W   (ACC_W),
            .GUARD_W (GUARD_W),
            .RND_BIT (RND_BIT)
        ) i_alu (
            .op_i       (op_i),
            .sel_i      (acc_sel_i == 1'(g)),
            .round_i    (round_i),
            .sat_mode_i (sat_mode_i),
            .acc_i      (state_q.acc[g]),
            .prod_i     (prod),
            .acc_o      (alu_acc[g]),
            .ovf_set_o  (alu_ovf[g])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_ACC; i++) begin
            state_d.acc[i] = alu_acc[i];
            state_d.ovf[i] = (state_q.ovf[i] & ~ovf_clr_i[i]) | alu_ovf[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_a_o = state_q.acc[0];
    assign acc_b_o = state_q.acc[1];
    assign ovf_o   = state_q.ovf;

endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk
    import frac_mac_pkg::*;
#(
    parameter int OPND_W  = 17,
    parameter int RANGE_W = 32,
    parameter int GUARD_W = 8,
    parameter int RND_BIT = 15
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2:0]                 op_i,
    input logic                       acc_sel_i,
    input logic                       round_i,
    input logic                       sat_mode_i,
    input logic [1:0]                 ovf_clr_i,
    input logic [RANGE_W+GUARD_W-1:0] acc_a_o,
    input logic [RANGE_W+GUARD_W-1:0] acc_b_o,
    input logic [1:0]                 ovf_o
);
    localparam int ACC_W = RANGE_W + GUARD_W;
    localparam int TOP_W = GUARD_W + 1;

    logic a_in_range, b_in_range;
    logic is_mul, is_acc_op;

    assign a_in_range = (&acc_a_o[ACC_W-1 -: TOP_W]) || !(|acc_a_o[ACC_W-1 -: TOP_W]);
    assign b_in_range = (&acc_b_o[ACC_W-1 -: TOP_W]) || !(|acc_b_o[ACC_W-1 -: TOP_W]);
    assign is_mul     = (op_i == OP_MPY) || (op_i == OP_MAC) || (op_i == OP_MAS);
    assign is_acc_op  = (op_i == OP_MAC) || (op_i == OP_MAS);

    AST_ZERO_CLEARS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ZERO && !acc_sel_i) |=> (acc_a_o == '0));                       // R11
    AST_UNSEL_B_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_sel_i) |=> $stable(acc_b_o));                                         // R2
    AST_UNSEL_A_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel_i) |=> $stable(acc_a_o));                                          // R2
    AST_SAT_OP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SAT) |=> (acc_sel_i ? b_in_range : a_in_range) || !rst_n);      // R8
    AST_SATMODE_RANGE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_mode_i && is_acc_op && !acc_sel_i) |=> a_in_range);                    // R9
    AST_ROUND_LOW_CLEAR_B: assert property (@(posedge clk) disable iff (!rst_n)
        (round_i && !sat_mode_i && is_mul && acc_sel_i) |=> (acc_b_o[RND_BIT:0] == '0)); // R7
    AST_OVF_STICKY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o[0] && !ovf_clr_i[0]) |=> ovf_o[0]);                                  // R10
    AST_OVF_STICKY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o[1] && !ovf_clr_i[1]) |=> ovf_o[1]);                                  // R10
    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP) |=> ($stable(acc_a_o) && $stable(acc_b_o)));               // R2

endmodule

bind frac_mac frac_mac_chk #(
    .OPND_W  (OPND_W),
    .RANGE_W (RANGE_W),
    .GUARD_W (GUARD_W),
    .RND_BIT (RND_BIT)
) i_frac_mac_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .acc_sel_i  (acc_sel_i),
    .round_i    (round_i),
    .sat_mode_i (sat_mode_i),
    .ovf_clr_i  (ovf_clr_i),
    .acc_a_o    (acc_a_o),
    .acc_b_o    (acc_b_o),
    .ovf_o      (ovf_o)
);

// File: tb/test_frac_mac.sv
`timescale 1ns/1ps
module test_frac_mac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'b000;
    logic        acc_sel_i = 1'b0;
    logic        frac_i = 1'b0;
    logic        round_i = 1'b0;
    logic        sat_mode_i = 1'b0;
    logic [16:0] xm_i = '0;
    logic [16:0] ym_i = '0;
    logic [1:0]  ovf_clr_i = 2'b00;
    logic [39:0] acc_a_o, acc_b_o;
    logic [1:0]  ovf_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    longint m_acc [2];
    bit     m_ovf [2];

    localparam logic [2:0] C_NOP = 3'b000, C_ZERO = 3'b001, C_MPY = 3'b010,
                           C_MAC = 3'b011, C_MAS = 3'b100, C_SAT = 3'b101;
    localparam longint MAX32 = 64'sd2147483647;
    localparam longint MIN32 = -64'sd2147483648;

    always #2.5 clk = ~clk;

    frac_mac i_frac_mac (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_sel_i(acc_sel_i),
        .frac_i(frac_i), .round_i(round_i), .sat_mode_i(sat_mode_i),
        .xm_i(xm_i), .ym_i(ym_i), .ovf_clr_i(ovf_clr_i),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .ovf_o(ovf_o)
    );

    function automatic longint s40(input longint v);
        logic [39:0] t;
        t = v[39:0];
        return longint'($signed(t));
    endfunction

    function automatic longint s17(input logic [16:0] v);
        return longint'($signed(v));
    endfunction

    function automatic bit oor(input longint v);
        return (v > MAX32) || (v < MIN32);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, {24'h0, acc_a_o}, {24'h0, m_acc[0][39:0]});
        chk(req, {24'h0, acc_b_o}, {24'h0, m_acc[1][39:0]});
        chk(req, {62'h0, ovf_o},   {62'h0, m_ovf[1], m_ovf[0]});
    endtask

    // Reference update from the requirement text, then one clock and a check.
    task automatic issue(input string req, input logic [2:0] op, input bit sel,
                         input bit frac, input bit rnd, input bit satm,
                         input logic [16:0] x, input logic [16:0] y, input logic [1:0] clr);
        longint p, r;
        bit set;
        @(negedge clk);
        op_i = op; acc_sel_i = sel; frac_i = frac; round_i = rnd;
        sat_mode_i = satm; xm_i = x; ym_i = y; ovf_clr_i = clr;
        set = 1'b0;
        p = s17(x) * s17(y);
        if (frac) p = p * 2;
        r = m_acc[sel];
        case (op)
            C_ZERO: r = 0;
            C_MPY, C_MAC, C_MAS: begin
                if (op == C_MPY)      r = s40(p);
                else if (op == C_MAC) r = s40(m_acc[sel] + p);
                else                  r = s40(m_acc[sel] - p);
                if (rnd) r = s40((r + 32768) & ~64'hFFFF);
                set = oor(r);
                if (satm && op != C_MPY && set) r = (r < 0) ? MIN32 : MAX32;
            end
            C_SAT: begin
                set = oor(r);
                if (set) r = (r < 0) ? MIN32 : MAX32;
            end
            default: ;
        endcase
        if (op == C_ZERO || op == C_MPY || op == C_MAC || op == C_MAS || op == C_SAT)
            m_acc[sel] = r;
        for (int i = 0; i < 2; i++) m_ovf[i] = m_ovf[i] & ~clr[i];
        if (set) m_ovf[sel] = 1'b1;
        @(negedge clk);
        op_i = C_NOP; ovf_clr_i = 2'b00; round_i = 1'b0; sat_mode_i = 1'b0;
        check_all(req);
    endtask

    task automatic t_reset();
        m_acc[0] = 0; m_acc[1] = 0; m_ovf[0] = 0; m_ovf[1] = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
    endtask

    task automatic t_mpy();
        issue("R3 mpy int max",  C_MPY, 0, 0, 0, 0, 17'h07FFF, 17'h07FFF, 2'b00);
        issue("R3 mpy neg",      C_MPY, 1, 0, 0, 0, 17'h1FFFD, 17'h00123, 2'b00);
        issue("R6 mpy -65536^2", C_MPY, 0, 0, 0, 0, 17'h10000, 17'h10000, 2'b00);
        chk("R6 guard value", {24'h0, acc_a_o}, 64'h0000000100000000);
    endtask

    task automatic t_frac();
        issue("R4 frac max",     C_MPY, 1, 1, 0, 0, 17'h07FFF, 17'h07FFF, 2'b10);
        chk("R4 frac value", {24'h0, acc_b_o}, 64'h000000007FFE0002);
        issue("R4 frac -1*-1",   C_MPY, 1, 1, 0, 0, 17'h18000, 17'h18000, 2'b00);
        issue("R4 frac mixed",   C_MPY, 0, 1, 0, 0, 17'h04000, 17'h1C000, 2'b01);
    endtask

    task automatic t_mac_mas();
        issue("R11 zero A", C_ZERO, 0, 0, 0, 0, 17'h0, 17'h0, 2'b11);
        issue("R11 zero B", C_ZERO, 1, 0, 0, 0, 17'h0, 17'h0, 2'b00);
        issue("R5 mac",     C_MAC, 0, 1, 0, 0, 17'h01234, 17'h00567, 2'b00);
        issue("R5 mac",     C_MAC, 0, 1, 0, 0, 17'h1F000, 17'h00400, 2'b00);
        issue("R5 mas",     C_MAS, 0, 0, 0, 0, 17'h00100, 17'h00100, 2'b00);
        issue("R5 mas B",   C_MAS, 1, 1, 0, 0, 17'h00010, 17'h1FFF0, 2'b00);
    endtask

    task automatic t_guard();
        issue("R11 zero A", C_ZERO, 0, 0, 0, 0, 17'h0, 17'h0, 2'b01);
        for (int k = 0; k < 4; k++)
            issue("R6 guard accumulate", C_MAC, 0, 1, 0, 0, 17'h07FFF, 17'h07FFF, 2'b00);
        chk("R6 no clamp", {24'h0, acc_a_o}, 64'h00000001FFF80008);
        chk("R6 flag", {62'h0, ovf_o[0]}, 64'h1);
        issue("R8 sat pos", C_SAT, 0, 0, 0, 0, 17'h0, 17'h0, 2'b00);
        chk("R8 pos limit", {24'h0, acc_a_o}, 64'h000000007FFFFFFF);
    endtask

    task automatic t_round();
        issue("R7 mpy round",  C_MPY, 1, 0, 1, 0, 17'h00003, 17'h05555, 2'b11);
        chk("R7 round value", {24'h0, acc_b_o}, 64'h0000000000010000);
        issue("R7 mac round",  C_MAC, 1, 1, 1, 0, 17'h00123, 17'h00045, 2'b00);
        issue("R7 mas round",  C_MAS, 1, 1, 1, 0, 17'h07000, 17'h00007, 2'b00);
        issue("R7 round down", C_MPY, 0, 0, 1, 0, 17'h00001, 17'h07FFF, 2'b00);
        chk("R7 round down value", {24'h0, acc_a_o}, 64'h0);
    endtask

    task automatic t_sat();
        issue("R11 zero B", C_ZERO, 1, 0, 0, 0, 17'h0, 17'h0, 2'b11);
        for (int k = 0; k < 3; k++)
            issue("R6 guard subtract", C_MAS, 1, 1, 0, 0, 17'h07FFF, 17'h07FFF, 2'b00);
        issue("R8 sat neg",   C_SAT, 1, 0, 0, 0, 17'h0, 17'h0, 2'b10);
        chk("R8 neg limit", {24'h0, acc_b_o}, 64'h000000FF80000000);
        issue("R8 sat in range", C_SAT, 1, 0, 0, 0, 17'h0, 17'h0, 2'b10);
        chk("R8 no flag", {62'h0, ovf_o[1]}, 64'h0);
    endtask

    task automatic t_satmode();
        issue("R11 zero A", C_ZERO, 0, 0, 0, 0, 17'h0, 17'h0, 2'b11);
        for (int k = 0; k < 3; k++)
            issue("R9 clamp mac", C_MAC, 0, 1, 0, 1, 17'h07FFF, 17'h07FFF, 2'b00);
        chk("R9 pos clamp", {24'h0, acc_a_o}, 64'h000000007FFFFFFF);
        for (int k = 0; k < 3; k++)
            issue("R9 clamp mas", C_MAS, 0, 1, 0, 1, 17'h07FFF, 17'h07FFF, 2'b00);
        issue("R9 mpy not clamped", C_MPY, 1, 0, 0, 1, 17'h10000, 17'h10000, 2'b00);
    endtask

    task automatic t_ovf_nop();
        issue("R10 hold",           C_NOP, 0, 0, 0, 0, 17'h1, 17'h1, 2'b00);
        issue("R10 clear A",        C_NOP, 0, 0, 0, 0, 17'h1, 17'h1, 2'b01);
        issue("R10 set beats clear", C_MPY, 0, 0, 0, 0, 17'h10000, 17'h10000, 2'b01);
        issue("R2 reserved 6",      3'b110, 0, 1, 0, 0, 17'h07FFF, 17'h07FFF, 2'b00);
        issue("R2 reserved 7",      3'b111, 1, 1, 0, 0, 17'h07FFF, 17'h07FFF, 2'b00);
        issue("R11 zero keeps flag", C_ZERO, 0, 0, 0, 0, 17'h0, 17'h0, 2'b00);
        issue("R10 clear both",     C_NOP, 0, 0, 0, 0, 17'h0, 17'h0, 2'b11);
    endtask

    initial begin
        t_reset();
        t_mpy();
        t_frac();
        t_mac_mas();
        t_guard();
        t_round();
        t_sat();
        t_satmode();
        t_ovf_nop();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule